// File: doc/BRIEF.md
# Byte-Scaled Address Generation Unit

This block forms 16-bit byte effective addresses for a core whose data path is 16 bits wide. Each request selects one of several addressing forms: a short absolute field that is zero-extended and so reaches only the low 8 KB, a full 16-bit absolute field, or a working-register pointer used either as it is or with a pre- or post-modification. The modification step scales with the operand size. It is one byte for byte operations and two bytes for word operations. Wrap-around uses 16-bit modulo arithmetic.

There are two copies of the generator, a read channel and a write channel. One instruction can therefore form a source address and a destination address in the same cycle, and neither copy affects the other. Each channel registers its result. One cycle after a request it presents the effective address, the pointer value to write back to the register file, and a write-back enable. The enable is raised only by forms that change the pointer. The register file, the memory array and instruction decode sit outside the block.

Top module: `agu_top`

## Requirements
- R1: Mode code 0 (short direct) gives an address equal to the low 13 bits of the immediate, zero-extended, so it always lies in 0x0000 to 0x1FFF. Immediate bits 15 to 13 are ignored.
- R2: Mode code 1 (long direct) passes all 16 immediate bits through as the address.
- R3: The pointer step is 1 when the word flag is 0 (byte operation) and 2 when the word flag is 1 (word operation).
- R4: Mode code 3 (post-increment) and mode code 4 (post-decrement) output the unmodified pointer as the address. They return the pointer plus or minus the step for write-back.
- R5: Mode code 5 (pre-increment) and mode code 6 (pre-decrement) output the modified pointer as both the address and the write-back value.
- R6: Pointer arithmetic wraps modulo 2^16 in both directions.
- R7: Mode code 2 (plain indirect) outputs the pointer as the address. Mode code 7 (reserved) behaves the same way. These two modes and both direct modes return the pointer unchanged with the write-back enable low. Modes 3 to 6 raise the enable.
- R8: The read channel and the write channel compute independently. A request on one channel never changes the outputs of the other.
- R9: Results appear on the outputs one clock after a valid request, with the address-valid output high. In a cycle with no request, address-valid and write-back enable drop to 0 and the address and write-back values hold.
- R10: While the active-low reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | Read-channel request |
| rdMode | input | 3 | Read-channel addressing mode code |
| rdImm | input | 16 | Read-channel immediate address field |
| rdPtr | input | 16 | Read-channel working-register pointer |
| rdWordOp | input | 1 | Read-channel operand size, 1 = word |
| wrValid | input | 1 | Write-channel request |
| wrMode | input | 3 | Write-channel addressing mode code |
| wrImm | input | 16 | Write-channel immediate address field |
| wrPtr | input | 16 | Write-channel working-register pointer |
| wrWordOp | input | 1 | Write-channel operand size, 1 = word |
| rdEa | output | 16 | Read-channel effective byte address |
| rdPtrNext | output | 16 | Read-channel pointer write-back value |
| rdPtrWe | output | 1 | Read-channel pointer write-back enable |
| rdEaValid | output | 1 | Read-channel result valid |
| wrEa | output | 16 | Write-channel effective byte address |
| wrPtrNext | output | 16 | Write-channel pointer write-back value |
| wrPtrWe | output | 1 | Write-channel pointer write-back enable |
| wrEaValid | output | 1 | Write-channel result valid |

## Verification
Some properties are checked on every cycle by the assertions. They cover the 8 KB bound of the short form and the one-or-two magnitude of each pointer step. They also cover the rule that post forms emit the old pointer while pre forms emit the written-back value, the absence of write-back for non-modifying forms, and the held outputs in idle cycles. The bench scenarios cover the rest. They show the exact values for each mode and size, wrap-around at 0x0000 and 0xFFFF, and the masking of immediate bits above the short field. They also show that each channel stays isolated while the other is busy or idle, and that a reset in mid-run clears the outputs.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    MODE_SHORT_DIR = 3'd0,
    MODE_LONG_DIR  = 3'd1,
    MODE_IND       = 3'd2,
    MODE_POST_INC  = 3'd3,
    MODE_POST_DEC  = 3'd4,
    MODE_PRE_INC   = 3'd5,
    MODE_PRE_DEC   = 3'd6,
    MODE_RESERVED  = 3'd7
  } agu_mode_e;

  // strobes from mode decode to the address datapath
  typedef struct packed {
    logic selImm;    // address comes from the immediate field
    logic selShort;  // immediate is the short, zero-extended form
    logic stepEn;    // pointer is modified and written back
    logic stepNeg;   // modification subtracts the step
    logic preMod;    // modified pointer is used as the address
    logic wordOp;    // step of two instead of one
  } agu_strobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic [2:0]  modeIn,
  input  logic        wordOpIn,
  output agu_strobe_t strobe
);

  agu_mode_e mode;
  assign mode = agu_mode_e'(modeIn);

  always_comb begin
    strobe = '0;
    strobe.wordOp = wordOpIn;
    case (mode)
      MODE_SHORT_DIR: begin
        strobe.selImm   = 1'b1;
        strobe.selShort = 1'b1;
      end
      MODE_LONG_DIR: begin
        strobe.selImm = 1'b1;
      end
      MODE_POST_INC: begin
        strobe.stepEn = 1'b1;
      end
      MODE_POST_DEC: begin
        strobe.stepEn  = 1'b1;
        strobe.stepNeg = 1'b1;
      end
      MODE_PRE_INC: begin
        strobe.stepEn = 1'b1;
        strobe.preMod = 1'b1;
      end
      MODE_PRE_DEC: begin
        strobe.stepEn  = 1'b1;
        strobe.stepNeg = 1'b1;
        strobe.preMod  = 1'b1;
      end
      default: begin
        // plain indirect and the reserved code: pointer as address, no write-back
      end
    endcase
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int SHORTW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          validIn,
  input  agu_strobe_t   strobe,
  input  logic [AW-1:0] immIn,
  input  logic [AW-1:0] ptrIn,
  output logic [AW-1:0] eaOut,
  output logic [AW-1:0] ptrNextOut,
  output logic          ptrWeOut,
  output logic          eaValidOut
);

  localparam int PADW = AW - SHORTW;

  logic [AW-1:0] step;
  logic [AW-1:0] modPtr;
  logic [AW-1:0] immEa;
  logic [AW-1:0] eaD;
  logic [AW-1:0] ptrNextD;

  logic [AW-1:0] eaQ;
  logic [AW-1:0] ptrNextQ;
  logic          ptrWeQ;
  logic          validQ;

  // byte step is 1, word step is 2
  assign step = {{(AW-2){1'b0}}, strobe.wordOp, ~strobe.wordOp};

  // one adder/subtractor serves pre and post forms; wraps modulo 2^AW
  assign modPtr = strobe.stepNeg ? (ptrIn - step) : (ptrIn + step);

  assign immEa = strobe.selShort ? {{PADW{1'b0}}, immIn[SHORTW-1:0]} : immIn;

  always_comb begin
    if (strobe.selImm)
      eaD = immEa;
    else if (strobe.preMod)
      eaD = modPtr;
    else
      eaD = ptrIn;
  end

  assign ptrNextD = strobe.stepEn ? modPtr : ptrIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ      <= '0;
      ptrNextQ <= '0;
      ptrWeQ   <= 1'b0;
      validQ   <= 1'b0;
    end else if (validIn) begin
      eaQ      <= eaD;
      ptrNextQ <= ptrNextD;
      ptrWeQ   <= strobe.stepEn;
      validQ   <= 1'b1;
    end else begin
      ptrWeQ   <= 1'b0;
      validQ   <= 1'b0;
    end
  end

  assign eaOut      = eaQ;
  assign ptrNextOut = ptrNextQ;
  assign ptrWeOut   = ptrWeQ;
  assign eaValidOut = validQ;

  // ---------------------------------------------------------------
  // assertions
  // ---------------------------------------------------------------
  logic [AW-1:0] chkStep;
  assign chkStep = strobe.wordOp ? AW'(2) : AW'(1);

  AST_SHORT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && strobe.selImm && strobe.selShort) |=> (eaOut[AW-1:SHORTW] == '0)); // R1

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && strobe.stepEn) |=>
      ((ptrNextOut == $past(ptrIn) + $past(chkStep)) ||
       (ptrNextOut == $past(ptrIn) - $past(chkStep)))); // R3

  AST_POST_OLD_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && strobe.stepEn && !strobe.preMod) |=> (eaOut == $past(ptrIn))); // R4

  AST_PRE_EA_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && strobe.preMod) |=> (eaOut == ptrNextOut && ptrWeOut)); // R5

  AST_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !strobe.stepEn) |=> (!ptrWeOut && ptrNextOut == $past(ptrIn))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!eaValidOut && !ptrWeOut && $stable(eaOut) && $stable(ptrNextOut))); // R9

  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ptrWeOut |-> eaValidOut); // R9

endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int SHORTW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdValid,
  input  logic [2:0]    rdMode,
  input  logic [AW-1:0] rdImm,
  input  logic [AW-1:0] rdPtr,
  input  logic          rdWordOp,
  input  logic          wrValid,
  input  logic [2:0]    wrMode,
  input  logic [AW-1:0] wrImm,
  input  logic [AW-1:0] wrPtr,
  input  logic          wrWordOp,
  output logic [AW-1:0] rdEa,
  output logic [AW-1:0] rdPtrNext,
  output logic          rdPtrWe,
  output logic          rdEaValid,
  output logic [AW-1:0] wrEa,
  output logic [AW-1:0] wrPtrNext,
  output logic          wrPtrWe,
  output logic          wrEaValid
);

  localparam int NCH = 2;  // channel 0 reads, channel 1 writes

  logic          chValid   [NCH];
  logic [2:0]    chMode    [NCH];
  logic [AW-1:0] chImm     [NCH];
  logic [AW-1:0] chPtr     [NCH];
  logic          chWordOp  [NCH];
  logic [AW-1:0] chEa      [NCH];
  logic [AW-1:0] chPtrNext [NCH];
  logic          chPtrWe   [NCH];
  logic          chEaValid [NCH];

  assign chValid[0]  = rdValid;
  assign chMode[0]   = rdMode;
  assign chImm[0]    = rdImm;
  assign chPtr[0]    = rdPtr;
  assign chWordOp[0] = rdWordOp;
  assign chValid[1]  = wrValid;
  assign chMode[1]   = wrMode;
  assign chImm[1]    = wrImm;
  assign chPtr[1]    = wrPtr;
  assign chWordOp[1] = wrWordOp;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    agu_strobe_t strobe;

    agu_ctrl u_ctrl (
      .modeIn   (chMode[ch]),
      .wordOpIn (chWordOp[ch]),
      .strobe   (strobe)
    );

    agu_datapath #(.AW(AW), .SHORTW(SHORTW)) u_dp (
      .clk        (clk),
      .rstN       (rstN),
      .validIn    (chValid[ch]),
      .strobe     (strobe),
      .immIn      (chImm[ch]),
      .ptrIn      (chPtr[ch]),
      .eaOut      (chEa[ch]),
      .ptrNextOut (chPtrNext[ch]),
      .ptrWeOut   (chPtrWe[ch]),
      .eaValidOut (chEaValid[ch])
    );
  end

  assign rdEa      = chEa[0];
  assign rdPtrNext = chPtrNext[0];
  assign rdPtrWe   = chPtrWe[0];
  assign rdEaValid = chEaValid[0];
  assign wrEa      = chEa[1];
  assign wrPtrNext = chPtrNext[1];
  assign wrPtrWe   = chPtrWe[1];
  assign wrEaValid = chEaValid[1];

endmodule

// File: tb/tb_agu_top.sv
`timescale 1ns/1ps
module tb_agu_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rdValid, wrValid;
  logic [2:0]  rdMode, wrMode;
  logic [15:0] rdImm, rdPtr, wrImm, wrPtr;
  logic        rdWordOp, wrWordOp;
  logic [15:0] rdEa, rdPtrNext, wrEa, wrPtrNext;
  logic        rdPtrWe, rdEaValid, wrPtrWe, wrEaValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  agu_top dut (
    .clk(clk), .rstN(rstN),
    .rdValid(rdValid), .rdMode(rdMode), .rdImm(rdImm), .rdPtr(rdPtr), .rdWordOp(rdWordOp),
    .wrValid(wrValid), .wrMode(wrMode), .wrImm(wrImm), .wrPtr(wrPtr), .wrWordOp(wrWordOp),
    .rdEa(rdEa), .rdPtrNext(rdPtrNext), .rdPtrWe(rdPtrWe), .rdEaValid(rdEaValid),
    .wrEa(wrEa), .wrPtrNext(wrPtrNext), .wrPtrWe(wrPtrWe), .wrEaValid(wrEaValid)
  );

  // {mode, word, imm, ptr, expEa, expPtrNext, expWe}
  localparam int NV = 16;
  localparam logic [68:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'hFFFF, 16'h1234, 16'h1FFF, 16'h1234, 1'b0},  // R1 upper imm bits masked
    {3'd0, 1'b1, 16'h0800, 16'h0000, 16'h0800, 16'h0000, 1'b0},  // R1
    {3'd1, 1'b0, 16'hFFFF, 16'h0042, 16'hFFFF, 16'h0042, 1'b0},  // R2
    {3'd2, 1'b1, 16'h0000, 16'h0800, 16'h0800, 16'h0800, 1'b0},  // R7
    {3'd3, 1'b0, 16'h0000, 16'h0800, 16'h0800, 16'h0801, 1'b1},  // R3 R4
    {3'd3, 1'b1, 16'h0000, 16'h0800, 16'h0800, 16'h0802, 1'b1},  // R3 R4
    {3'd4, 1'b0, 16'h0000, 16'h0800, 16'h0800, 16'h07FF, 1'b1},  // R4
    {3'd4, 1'b1, 16'h0000, 16'h0800, 16'h0800, 16'h07FE, 1'b1},  // R4
    {3'd5, 1'b1, 16'h0000, 16'h0800, 16'h0802, 16'h0802, 1'b1},  // R5
    {3'd6, 1'b0, 16'h0000, 16'h0800, 16'h07FF, 16'h07FF, 1'b1},  // R5
    {3'd3, 1'b1, 16'h0000, 16'hFFFE, 16'hFFFE, 16'h0000, 1'b1},  // R6
    {3'd4, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'hFFFE, 1'b1},  // R6
    {3'd5, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 1'b1},  // R6
    {3'd7, 1'b1, 16'h0000, 16'h0ABC, 16'h0ABC, 16'h0ABC, 1'b0},  // R7 reserved
    {3'd0, 1'b0, 16'h2000, 16'h5555, 16'h0000, 16'h5555, 1'b0},  // R1 bit 13 dropped
    {3'd6, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 16'hFFFF, 1'b1}   // R5 R6
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    rdValid = 0; rdMode = 0; rdImm = 0; rdPtr = 0; rdWordOp = 0;
    wrValid = 0; wrMode = 0; wrImm = 0; wrPtr = 0; wrWordOp = 0;
    repeat (3) @(negedge clk);
    check(rdEa, 16'h0, "R10 reset rdEa");
    check({15'd0, rdEaValid}, 16'h0, "R10 reset rdEaValid");
    check({15'd0, wrPtrWe}, 16'h0, "R10 reset wrPtrWe");
    rstN = 1'b1;

    // table walk: read channel gets vector i, write channel vector NV-1-i
    for (int i = 0; i < NV; i++) begin
      logic [68:0] a;
      logic [68:0] b;
      a = VEC[i];
      b = VEC[NV-1-i];
      rdValid = 1; rdMode = a[68:66]; rdWordOp = a[65]; rdImm = a[64:49]; rdPtr = a[48:33];
      wrValid = 1; wrMode = b[68:66]; wrWordOp = b[65]; wrImm = b[64:49]; wrPtr = b[48:33];
      @(negedge clk);
      check(rdEa, a[32:17], $sformatf("R1-style vec %0d rd ea (R1 R2 R4 R5 R6)", i));
      check(rdPtrNext, a[16:1], $sformatf("vec %0d rd ptrNext R3 R4 R6", i));
      check({15'd0, rdPtrWe}, {15'd0, a[0]}, $sformatf("vec %0d rd ptrWe R7", i));
      check({15'd0, rdEaValid}, 16'h1, $sformatf("vec %0d rd valid R9", i));
      check(wrEa, b[32:17], $sformatf("vec %0d wr ea R8", i));
      check(wrPtrNext, b[16:1], $sformatf("vec %0d wr ptrNext R8", i));
      check({15'd0, wrPtrWe}, {15'd0, b[0]}, $sformatf("vec %0d wr ptrWe R8", i));
    end

    // R9: idle cycle holds address, drops valid and write-back
    rdValid = 0; wrValid = 0;
    rdPtr = 16'h7777; rdMode = 3'd3;
    @(negedge clk);
    check({15'd0, rdEaValid}, 16'h0, "R9 idle rdEaValid");
    check({15'd0, rdPtrWe}, 16'h0, "R9 idle rdPtrWe");
    check(rdEa, 16'hFFFF, "R9 idle rdEa hold");
    check(rdPtrNext, 16'hFFFF, "R9 idle rdPtrNext hold");

    // R8: read channel busy while write channel idle
    rdValid = 1; rdMode = 3'd1; rdImm = 16'hBEEF; rdWordOp = 0;
    wrValid = 0; wrMode = 3'd5; wrPtr = 16'h1111;
    @(negedge clk);
    check(rdEa, 16'hBEEF, "R2 long direct");
    check(wrEa, 16'h1FFF, "R8 write channel untouched ea");
    check({15'd0, wrEaValid}, 16'h0, "R8 write channel stays invalid");

    // R8 reverse: write busy, read idle
    rdValid = 0;
    wrValid = 1; wrMode = 3'd4; wrWordOp = 1; wrPtr = 16'h0100;
    @(negedge clk);
    check(wrEa, 16'h0100, "R4 write post-dec ea");
    check(wrPtrNext, 16'h00FE, "R3 write post-dec word step");
    check(rdEa, 16'hBEEF, "R8 read channel untouched ea");
    check({15'd0, rdEaValid}, 16'h0, "R8 read channel invalid");

    // R10: reset in mid-run
    wrValid = 0;
    rstN = 1'b0;
    @(negedge clk);
    check(rdEa, 16'h0, "R10 mid reset rdEa");
    check(wrPtrNext, 16'h0, "R10 mid reset wrPtrNext");
    check({15'd0, wrEaValid}, 16'h0, "R10 mid reset wrEaValid");
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end

endmodule